// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block turns the input levels of a small GPIO port into interrupt requests. Every pin has two configuration bits, one choosing between level and edge sensing and one choosing the active sense (low/falling or high/rising). Edge events are held in a per-pin latch until software acknowledges them with a write-one-to-clear operation. Level conditions are never latched and follow the pin directly.

An enable mask decides which pins may raise an interrupt. The block reports two status vectors, one before and one after the mask. It drives a single combined request for ports that share one controller input, and a separate request per pin for ports whose lines each go to their own controller input. Edge latching goes on while a pin is masked, so a pin that is enabled later shows at once any event it caught while masked.

Software can detect both edges by flipping a pin's polarity bit after each acknowledged edge. For this to work, every edge comparison uses the polarity value held at that moment. Pin inputs are assumed to be already synchronised to `clk`.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the type, polarity and enable registers are all zero, no edge event is pending, and `masked_status`, `irq_pin` and `irq_comb` are all zero.
- R2: For a pin whose type bit is 0 (level), `raw_status` is 1 in the same cycle exactly when the pin equals its polarity bit (0 = active low, 1 = active high). No state is kept.
- R3: For a pin whose type bit is 1 (edge), polarity 1 captures a 0-to-1 change and polarity 0 captures a 1-to-0 change. The change is judged against the value sampled one clock earlier, and `raw_status` shows the event from the cycle after the clock edge that sampled it.
- R4: A captured edge event stays pending until a write of 1 to that pin's bit with selector 2'b11 (end of interrupt). Bits written as 0 leave their pins untouched.
- R5: If an end-of-interrupt write and a new captured edge reach the same pin on the same clock, the event stays pending.
- R6: `masked_status` equals `raw_status` ANDed with the enable register (selector 2'b10). Edge events are still captured while the pin's enable bit is 0.
- R7: `irq_pin[i]` equals `masked_status[i]`, and `irq_comb` is 1 exactly when any bit of `masked_status` is 1.
- R8: End-of-interrupt writes have no effect on a pin in level mode. Changing a pin's type or polarity clears no pending event: the event shows again when the pin returns to edge mode.
- R9: Each edge comparison uses the polarity bit held at that moment, so flipping the polarity after an acknowledged rising edge makes the next falling edge get captured.
- R10: Writes happen when `wr_en` is 1 on a rising edge of `clk`. `wr_sel` selects the target: 2'b00 type (1 = edge), 2'b01 polarity, 2'b10 enable, 2'b11 end of interrupt. Bit i of `wr_data` applies to pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | W | Synchronised pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 type, 1 polarity, 2 enable, 3 end of interrupt |
| wr_data | input | W | Write data, one bit per pin |
| raw_status | output | W | Per-pin pending condition before the enable mask |
| masked_status | output | W | Per-pin pending condition after the enable mask |
| irq_pin | output | W | Per-pin interrupt requests |
| irq_comb | output | 1 | OR of all masked requests |

## Verification
A stuck or lost edge latch shows up on `raw_status` one cycle after the sampling clock edge, whatever the enable state, so the bench reads it right after each edge and after each acknowledge. A delay flop that is wrong or out of step either misses an edge or captures a false one on the pin that moved, and this shows in the next cycle. Errors in the enable path or in the level comparison appear combinationally on `masked_status`, `irq_pin` and `irq_comb` in the same cycle as the input change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    SEL_TYPE = 2'b00,
    SEL_POL  = 2'b01,
    SEL_EN   = 2'b10,
    SEL_EOI  = 2'b11
  } wsel_e;

  // Edge qualifier: the current sample differs from the previous one and
  // lands on the active level (pol=1 rising, pol=0 falling).
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return (cur != prev) && (cur == pol);
  endfunction

  // Level qualifier: the pin sits at the active level.
  function automatic logic level_match(input logic cur, input logic pol);
    return cur == pol;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] type_q,
  output logic [W-1:0] pol_q,
  output logic [W-1:0] en_q,
  output logic [W-1:0] eoi_pulse
);

  wsel_e sel;
  assign sel = wsel_e'(wr_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      type_q <= '0;
      pol_q  <= '0;
      en_q   <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_TYPE: type_q <= wr_data;
        SEL_POL:  pol_q  <= wr_data;
        SEL_EN:   en_q   <= wr_data;
        default:  ;
      endcase
    end
  end

  assign eoi_pulse = (wr_en && sel == SEL_EOI) ? wr_data : '0;

endmodule

// File: rtl/gpio_irq_lane.sv
module gpio_irq_lane
  import gpio_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic is_edge,
  input  logic pol,
  input  logic eoi,
  output logic raw,
  output logic ev_set,
  output logic ev_clr,
  output logic ev_lat,
  output logic pin_prev
);

  logic pin_q;
  logic lat_q;

  assign ev_set   = is_edge & edge_hit(pin, pin_q, pol);
  assign ev_clr   = eoi & is_edge;
  assign ev_lat   = lat_q;
  assign pin_prev = pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
      lat_q <= 1'b0;
    end else begin
      pin_q <= pin;
      lat_q <= ev_set | (lat_q & ~ev_clr);
    end
  end

  assign raw = is_edge ? lat_q : level_match(pin, pol);

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_in,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] raw_status,
  output logic [W-1:0] masked_status,
  output logic [W-1:0] irq_pin,
  output logic         irq_comb
);

  logic [W-1:0] type_r;
  logic [W-1:0] pol_r;
  logic [W-1:0] en_r;
  logic [W-1:0] eoi_p;
  logic [W-1:0] edge_set;
  logic [W-1:0] eoi_clr;
  logic [W-1:0] edge_lat;
  logic [W-1:0] pin_q;

  gpio_irq_cfg #(.W(W)) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .type_q    (type_r),
    .pol_q     (pol_r),
    .en_q      (en_r),
    .eoi_pulse (eoi_p)
  );

  for (genvar i = 0; i < W; i++) begin : g_lane
    gpio_irq_lane u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin      (pin_in[i]),
      .is_edge  (type_r[i]),
      .pol      (pol_r[i]),
      .eoi      (eoi_p[i]),
      .raw      (raw_status[i]),
      .ev_set   (edge_set[i]),
      .ev_clr   (eoi_clr[i]),
      .ev_lat   (edge_lat[i]),
      .pin_prev (pin_q[i])
    );
  end

  assign masked_status = raw_status & en_r;
  assign irq_pin       = masked_status;
  assign irq_comb      = |masked_status;

endmodule

module gpio_irq_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] pin_in,
  input logic [W-1:0] pin_q,
  input logic [W-1:0] type_r,
  input logic [W-1:0] pol_r,
  input logic [W-1:0] en_r,
  input logic [W-1:0] eoi_clr,
  input logic [W-1:0] edge_set,
  input logic [W-1:0] edge_lat,
  input logic [W-1:0] raw_status,
  input logic [W-1:0] irq_pin,
  input logic         irq_comb
);

  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(edge_lat) & ~$past(eoi_clr)) & ~edge_lat) == '0));

  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(edge_set) & ~edge_lat) == '0));

  // R3
  new_event_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((edge_lat & ~$past(edge_lat)) & ~$past(type_r & (pin_in ^ pin_q))) == '0));

  // R2
  level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((raw_status ^ ~(pin_in ^ pol_r)) & ~type_r) == '0);

  // R6
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pin & ~en_r) == '0);

  // R7
  comb_or_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_comb == (irq_pin != '0));

endmodule

bind gpio_irq_ctrl gpio_irq_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pin_in     (pin_in),
  .pin_q      (pin_q),
  .type_r     (type_r),
  .pol_r      (pol_r),
  .en_r       (en_r),
  .eoi_clr    (eoi_clr),
  .edge_set   (edge_set),
  .edge_lat   (edge_lat),
  .raw_status (raw_status),
  .irq_pin    (irq_pin),
  .irq_comb   (irq_comb)
);

// File: tb/gpio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_tb;

  localparam int W = 8;
  localparam logic [1:0] S_TYPE = 2'b00, S_POL = 2'b01, S_EN = 2'b10, S_EOI = 2'b11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = '0;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] raw_status, masked_status, irq_pin;
  logic         irq_comb;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .raw_status(raw_status), .masked_status(masked_status),
    .irq_pin(irq_pin), .irq_comb(irq_comb)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [W-1:0] d);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; pin_in = '0; wr_en = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 masked after reset", masked_status, 0);
    chk("R1 irq_pin after reset", irq_pin, 0);
    chk("R1 irq_comb after reset", irq_comb, 0);
    chk("R1 raw level-low default", raw_status, 8'hFF);
  endtask

  task automatic t_level();
    do_reset();
    wr(S_POL, 8'hF0); wr(S_EN, 8'h0F);
    pin_in = 8'hA5; #1;
    chk("R2 level raw", raw_status, 8'hAA);
    chk("R6 level masked", masked_status, 8'h0A);
    chk("R7 comb high", irq_comb, 1);
    pin_in = 8'h0F; #1;
    chk("R2 level no latch", raw_status, 8'h00);
    chk("R7 comb low", irq_comb, 0);
    pin_in = 8'hF0; tick();
    wr(S_EOI, 8'hFF);
    chk("R8 eoi ignored in level", raw_status, 8'hFF);
  endtask

  task automatic t_rise();
    do_reset();
    wr(S_TYPE, 8'hFF); wr(S_POL, 8'hFF);
    pin_in = 8'h01; tick();
    chk("R3 rising captured", raw_status, 8'h01);
    chk("R6 captured while disabled", masked_status, 8'h00);
    pin_in = 8'h00; tick();
    chk("R3 falling not captured", raw_status, 8'h01);
    wr(S_EN, 8'h01);
    chk("R6 pending shown on enable", masked_status, 8'h01);
    chk("R7 per-pin request", irq_pin, 8'h01);
    chk("R7 combined request", irq_comb, 1);
    wr(S_EOI, 8'h00);
    chk("R4 zero eoi no effect", raw_status, 8'h01);
    wr(S_EOI, 8'h01);
    chk("R4 eoi clears", raw_status, 8'h00);
    chk("R10 comb after clear", irq_comb, 0);
  endtask

  task automatic t_fall();
    do_reset();
    wr(S_TYPE, 8'hFF);
    pin_in = 8'h02; tick();
    chk("R3 rise ignored pol0", raw_status, 8'h00);
    pin_in = 8'h00; tick();
    chk("R3 falling captured pol0", raw_status, 8'h02);
  endtask

  task automatic t_collide();
    do_reset();
    wr(S_TYPE, 8'hFF); wr(S_POL, 8'hFF); wr(S_EN, 8'hFF);
    pin_in = 8'h04; tick();
    chk("R3 bit2 captured", raw_status, 8'h04);
    pin_in = 8'h00; tick();
    pin_in = 8'h04;
    wr(S_EOI, 8'h04);
    chk("R5 new edge wins over eoi", raw_status, 8'h04);
    wr(S_EOI, 8'h04);
    chk("R5 later eoi clears", raw_status, 8'h00);
  endtask

  task automatic t_both();
    do_reset();
    wr(S_TYPE, 8'hFF); wr(S_POL, 8'h08); wr(S_EN, 8'h08);
    pin_in = 8'h08; tick();
    chk("R9 first rising", raw_status, 8'h08);
    wr(S_EOI, 8'h08); wr(S_POL, 8'h00);
    chk("R9 cleared before fall", raw_status, 8'h00);
    pin_in = 8'h00; tick();
    chk("R9 falling after toggle", irq_pin, 8'h08);
  endtask

  task automatic t_retain();
    do_reset();
    wr(S_TYPE, 8'hFF); wr(S_POL, 8'h10);
    pin_in = 8'h10; tick();
    chk("R8 bit4 captured", raw_status, 8'h10);
    wr(S_TYPE, 8'hEF);
    pin_in = 8'h00; tick();
    chk("R8 level view of bit4", raw_status, 8'h00);
    wr(S_EOI, 8'h10);
    wr(S_TYPE, 8'hFF);
    chk("R8 event kept across type change", raw_status, 8'h10);
  endtask

  initial begin
    t_reset();
    t_level();
    t_rise();
    t_fall();
    t_collide();
    t_both();
    t_retain();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule